// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block holds the tags, valid flags and word data of a small two-way set-associative cache. Each set also keeps one guess bit that names the way its next access is likely to hit. A lookup steers the data multiplexer from that guess at once and compares only the guessed way's tag in the first lookup cycle. A correct guess answers in that cycle. When the guess is wrong, the other way is compared in the following cycle.

A lookup therefore ends in one of three ways. A fast hit answers one cycle after acceptance. A slow hit answers after two cycles and moves the guess to the way that hit. A miss raises a refill request and waits for the fill word. The fill word is written into the way the set did not guess, the guess then points at that way, and the fill word is returned as the response. Only one lookup is in flight at a time. Each address names one word: the low bits select the set and the remaining bits form the tag.

Top module: `wp_cache`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` and `miss_valid_o` are 0, every entry is invalid, and every set guesses way 0.
- R2: A request accepted at clock edge k whose guessed way holds the tag gives `rsp_valid_o`=1, `rsp_fast_o`=1 and the stored word in the cycle after edge k.
- R3: A request that hits only in the non-guessed way gives no response in the first cycle after acceptance. It gives `rsp_valid_o`=1 and `rsp_fast_o`=0 with the stored word in the second cycle.
- R4: After a slow hit, the set guesses the way that hit, so the next access to the same address is a fast hit.
- R5: A request that hits neither way raises `miss_valid_o` in the third cycle after acceptance, with `miss_addr_o` equal to the request address. Both hold until a fill arrives.
- R6: While a miss is pending, `fill_valid_i`=1 gives `rsp_valid_o`=1, `rsp_fast_o`=0 and `rsp_data_o`=`fill_data_i` in that same cycle. `req_ready_o` returns to 1 in the next cycle.
- R7: A fill is written into the way the set did not guess, and the set then guesses the filled way. The word in the other way is kept.
- R8: `req_ready_o` is 0 from acceptance until the lookup completes. A request presented while it is 0 is ignored.
- R9: Each set has its own guess. Lookups and fills in one set leave the guess of every other set unchanged.
- R10: `fill_valid_i` has no effect while no miss is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_addr_i | input | ADDR_W | Word address to look up |
| req_ready_o | output | 1 | Block can accept a request |
| rsp_valid_o | output | 1 | Response word valid |
| rsp_fast_o | output | 1 | Response came from a correct guess |
| rsp_data_o | output | DATA_W | Response word |
| miss_valid_o | output | 1 | Refill requested |
| miss_addr_o | output | ADDR_W | Address to refill |
| fill_valid_i | input | 1 | Refill word present |
| fill_data_i | input | DATA_W | Refill word for the pending miss |

## Verification
The assertions assume that the fill word arriving during a pending miss belongs to `miss_addr_o`. They also assume that `fill_valid_i` may arrive at any time after the miss is raised, including while idle. The stimulus serves each miss with the word the bench model computes from its address, one cycle after the miss is observed. It pulses a stray fill while the block is idle, and it presents stray requests only while `req_ready_o` is low. Those requests are withdrawn before the lookup completes, so none of them can be taken as a new request.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_REFILL = 2'd3
  } lk_state_e;
endpackage

// File: rtl/wp_tag_store.sv
module wp_tag_store #(
  parameter int WAYS  = 2,
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            rd_idx_i,
  input  logic                        wr_en_i,
  input  logic [$clog2(WAYS)-1:0]     wr_way_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  output logic [WAYS-1:0][TAG_W-1:0]  tag_o,
  output logic [WAYS-1:0]             valid_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic             sel;
    assign sel = wr_en_i && (wr_way_i == w);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= '0;
      else if (sel) vld_q[rd_idx_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) tag_q[rd_idx_i] <= wr_tag_i;
    end

    assign tag_o[w]   = tag_q[rd_idx_i];
    assign valid_o[w] = vld_q[rd_idx_i];
  end
endmodule

// File: rtl/wp_data_store.sv
module wp_data_store #(
  parameter int WAYS   = 2,
  parameter int SETS   = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                         clk_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic                         wr_en_i,
  input  logic [$clog2(WAYS)-1:0]      wr_way_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [WAYS-1:0][DATA_W-1:0]  rd_data_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [SETS];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_way_i == w)) mem_q[idx_i] <= wr_data_i;
    end
    assign rd_data_o[w] = mem_q[idx_i];
  end
endmodule

// File: rtl/wp_way_pred.sv
module wp_way_pred #(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             upd_en_i,
  input  logic             upd_way_i,
  output logic             guess_o
);
  logic [SETS-1:0] guess_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) guess_q <= '0;
    else if (upd_en_i) guess_q[idx_i] <= upd_way_i;
  end

  assign guess_o = guess_q[idx_i];
endmodule

// File: rtl/wp_cache.sv
module wp_cache
  import wp_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_fast_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              miss_valid_o,
  output logic [ADDR_W-1:0] miss_addr_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  lk_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              guess, cmp_way, hit, fill_we, upd_en;
  logic [WAYS-1:0][TAG_W-1:0]  tags;
  logic [WAYS-1:0]             valids;
  logic [WAYS-1:0][DATA_W-1:0] words;

  assign idx = addr_q[IDX_W-1:0];
  assign tag = addr_q[ADDR_W-1:IDX_W];

  // first cycle compares the guessed way, second the other one
  assign cmp_way = (state_q == ST_SECOND) ? ~guess : guess;
  assign hit     = valids[cmp_way] && (tags[cmp_way] == tag);
  assign fill_we = (state_q == ST_REFILL) && fill_valid_i;
  assign upd_en  = ((state_q == ST_SECOND) && hit) || fill_we;

  wp_way_pred #(.SETS(SETS)) i_pred (
    .clk_i, .rst_ni, .idx_i(idx), .upd_en_i(upd_en),
    .upd_way_i(~guess), .guess_o(guess)
  );

  wp_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) i_tags (
    .clk_i, .rst_ni, .rd_idx_i(idx), .wr_en_i(fill_we),
    .wr_way_i(~guess), .wr_tag_i(tag), .tag_o(tags), .valid_o(valids)
  );

  wp_data_store #(.WAYS(WAYS), .SETS(SETS), .DATA_W(DATA_W)) i_data (
    .clk_i, .idx_i(idx), .wr_en_i(fill_we), .wr_way_i(~guess),
    .wr_data_i(fill_data_i), .rd_data_o(words)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_FIRST;
      ST_FIRST:  state_d = hit ? ST_IDLE : ST_SECOND;
      ST_SECOND: state_d = hit ? ST_IDLE : ST_REFILL;
      ST_REFILL: if (fill_valid_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) addr_q <= req_addr_i;
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = (((state_q == ST_FIRST) || (state_q == ST_SECOND)) && hit) || fill_we;
  assign rsp_fast_o   = (state_q == ST_FIRST) && hit;
  assign rsp_data_o   = (state_q == ST_REFILL) ? fill_data_i : words[cmp_way];
  assign miss_valid_o = (state_q == ST_REFILL);
  assign miss_addr_o  = addr_q;

  // R8
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i) |=> !req_ready_o);
  // R2
  fast_is_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fast_o |-> (rsp_valid_o && !miss_valid_o));
  // R5
  miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_o && !fill_valid_i) |=> (miss_valid_o && $stable(miss_addr_o)));
  // R6
  fill_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_o && fill_valid_i) |-> (rsp_valid_o && rsp_data_o == fill_data_i)
    ##1 req_ready_o);
  // R10
  idle_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && fill_valid_i) |-> !rsp_valid_o);
endmodule

// File: tb/test_wp_cache.sv
module test_wp_cache;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SETS   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_fast, miss_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [ADDR_W-1:0] miss_addr;
  logic fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wp_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) i_wp_cache (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_fast_o(rsp_fast),
    .rsp_data_o(rsp_data), .miss_valid_o(miss_valid), .miss_addr_o(miss_addr),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data)
  );

  function automatic logic [DATA_W-1:0] word_of(logic [ADDR_W-1:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  function automatic logic [ADDR_W-1:0] mk(int t, int s);
    return ADDR_W'((t << 4) | s);
  endfunction

  task automatic chk(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 fast hit, 1 slow hit, 2 miss
  task automatic access(logic [ADDR_W-1:0] a, int kind, string req);
    chk(req_ready, {req, " ready before request"}, DATA_W'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (kind == 0) begin
      chk(rsp_valid && rsp_fast && rsp_data == word_of(a), {req, " fast hit"},
          rsp_data, word_of(a));
    end else begin
      chk(!rsp_valid && !req_ready, {req, " R8 no first-cycle response"},
          DATA_W'({rsp_valid, req_ready}), 0);
      req_valid = 1'b1;
      req_addr  = mk(9, 3);
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      if (kind == 1) begin
        chk(rsp_valid && !rsp_fast && rsp_data == word_of(a), {req, " slow hit"},
            rsp_data, word_of(a));
      end else begin
        chk(!rsp_valid && !miss_valid, {req, " no second-cycle response"},
            DATA_W'({rsp_valid, miss_valid}), 0);
        @(posedge clk); @(negedge clk);
        chk(miss_valid && miss_addr == a, {req, " R5 miss raised"},
            DATA_W'({miss_valid, miss_addr}), DATA_W'({1'b1, a}));
        req_valid = 1'b1;
        req_addr  = mk(9, 3);
        chk(!req_ready, {req, " R8 busy during miss"}, DATA_W'(req_ready), 0);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(miss_valid && miss_addr == a, {req, " R5 miss held"},
            DATA_W'(miss_addr), DATA_W'(a));
        fill_valid = 1'b1;
        fill_data  = word_of(a);
        #0;
        chk(rsp_valid && !rsp_fast && rsp_data == word_of(a), {req, " R6 fill response"},
            rsp_data, word_of(a));
        @(posedge clk); @(negedge clk);
        fill_valid = 1'b0;
        chk(req_ready && !miss_valid, {req, " R6 ready after fill"},
            DATA_W'({req_ready, miss_valid}), DATA_W'(2'b10));
        return;
      end
    end
    @(posedge clk); @(negedge clk);
    chk(req_ready, {req, " ready after response"}, DATA_W'(req_ready), 1);
  endtask

  task automatic t_reset();
    chk(req_ready && !rsp_valid && !miss_valid, "R1 reset outputs",
        DATA_W'({req_ready, rsp_valid, miss_valid}), DATA_W'(3'b100));
  endtask

  task automatic t_idle_fill();
    fill_valid = 1'b1;
    fill_data  = 32'hDEAD_BEEF;
    #0;
    chk(!rsp_valid, "R10 idle fill no response", DATA_W'(rsp_valid), 0);
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    chk(req_ready && !miss_valid, "R10 idle fill no state change",
        DATA_W'({req_ready, miss_valid}), DATA_W'(2'b10));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_fill();
    access(mk(1, 3), 2, "R1 cold miss");
    access(mk(1, 3), 0, "R7 guess points to filled way");
    access(mk(2, 3), 2, "R7 second tag miss");
    access(mk(2, 3), 0, "R2 fast hit");
    access(mk(1, 3), 1, "R3 mispredicted hit");
    access(mk(1, 3), 0, "R4 guess updated");
    access(mk(1, 5), 2, "R9 other set miss a");
    access(mk(2, 5), 2, "R9 other set miss b");
    access(mk(1, 3), 0, "R9 set 3 guess kept");
    access(mk(3, 3), 2, "R7 evict non-guessed way");
    access(mk(1, 3), 1, "R7 guessed way kept");
    access(mk(2, 3), 2, "R7 evicted tag misses");
    access(mk(1, 5), 1, "R9 set 5 slow hit");
    t_idle_fill();
    access(mk(1, 5), 0, "R10 contents intact");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule